// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block collects the fault indications of a power-management controller and decides how each one is handled. Every regulator has undervoltage, overcurrent (positive and negative limit), short-to-ground, thermal-warning, over-temperature, residual-voltage, residual-voltage-trip and discharge-timeout inputs. The supply has undervoltage, overvoltage and internal-rail inputs. For each fault the block picks a reaction: an immediate power-off, an immediate drop to the init state, a sequenced drop to the init state, or a report with no shutdown at all. It keeps one sticky status bit per fault, which software clears by writing ones. It drives a registered, active-low interrupt.

Three faults can be masked per regulator: undervoltage, thermal warning and residual voltage. A two-bit mask-response code decides whether a masked fault still sets its bit and whether it still raises the interrupt. Status bits that did not come from a shutdown are dropped when the controller enters its init state. A small restart machine counts shutdown faults and grants automatic restart while the enable input is high. It blocks restart once the retry budget is spent, and only reset (a supply power cycle) releases it.

The restart machine has three states. RUN is entered from reset and from a successful power-up. WAIT is entered from RUN on a new shutdown fault; further faults in WAIT add to the count. LOCK is entered from WAIT when a new fault arrives with the count already at the limit and the limit enabled. The edges are RUN→WAIT (new fault), WAIT→RUN (power-up done), WAIT→WAIT (new fault within budget) and WAIT→LOCK (new fault past budget). LOCK has no exit except reset.

Top module: `pmic_fault_mgr`

## Requirements
- R1: Overcurrent, short-to-ground, residual-voltage-trip and discharge-timeout faults have no mask. Each sets its status bit, drives req_seq high one clock later and pulls irq_n low. An over-temperature fault sets its bit and drives req_imm instead. Status groups are read at rd_addr: 0 undervoltage, 1 overcurrent, 2 short, 3 thermal warning, 4 over-temperature, 5 residual voltage, 6 residual trip, 7 discharge timeout, 8 supply. Bit i of a group is regulator i.
- R2: An unmasked undervoltage or thermal-warning fault sets its bit, drives req_seq and pulls irq_n low.
- R3: A masked undervoltage or thermal-warning fault never drives any request and never counts as a retry. With mask_rsp = 00 it also sets no bit and leaves irq_n high.
- R4: With mask_rsp = 01 a masked fault sets its bit and leaves irq_n high. With 10 or 11 it sets its bit and pulls irq_n low.
- R5: Positive and negative overcurrent on regulator i both map to the single bit i of group 1.
- R6: Supply faults set bits in group 8 (bit 0 undervoltage, bit 1 overvoltage, bit 2 internal rail) and drive req_off. At most one request is high at a time, with priority req_off > req_imm > req_seq.
- R7: Writing a one to a status bit clears it on the next clock only if its fault input is low in the write cycle. Otherwise the bit stays set.
- R8: A rising edge on st_init clears every status bit that was not set by a shutdown reaction. Shutdown bits are kept.
- R9: A residual-voltage fault never drives a request. Unmasked, it sets its bit and pulls irq_n low unless rv_irq_quiet is high. rv_irq_quiet has no effect on the interrupt of residual-trip bits.
- R10: After a shutdown fault, restart_ok goes high one clock after all shutdown faults are gone, but only while en_in is high. It drops when pu_done is seen.
- R11: With retry_unlimited low, a third shutdown fault without an intervening pu_done locks the block. restart_ok then stays low even after pu_done, until reset.
- R12: With retry_unlimited high, restart_ok comes back after every fault, without limit.
- R13: All outputs are registered with one clock of latency. After reset the requests, restart_ok and all status bits are 0 and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the supply power cycle |
| flt_uv | input | NREG | Regulator undervoltage |
| flt_oc_pos | input | NREG | Positive current limit |
| flt_oc_neg | input | NREG | Negative current limit |
| flt_scg | input | NREG | Short to ground |
| flt_thw | input | NREG | Thermal warning |
| flt_ots | input | NREG | Over-temperature shutdown |
| flt_rv | input | NREG | Residual voltage |
| flt_rvtrip | input | NREG | Residual-voltage trip |
| flt_dto | input | NREG | Discharge timeout |
| sup_uv | input | 1 | Supply undervoltage |
| sup_ov | input | 1 | Supply overvoltage |
| sup_int | input | 1 | Internal rail out of range |
| mask_uv | input | NREG | Undervoltage mask per regulator |
| mask_thw | input | NREG | Thermal-warning mask per regulator |
| mask_rv | input | NREG | Residual-voltage mask per regulator |
| mask_rsp | input | 2 | Reporting of masked faults |
| rv_irq_quiet | input | 1 | Keeps residual-voltage bits off the interrupt |
| retry_unlimited | input | 1 | Removes the retry limit |
| en_in | input | 1 | Enable request level |
| st_init | input | 1 | Controller is in its init state |
| pu_done | input | 1 | Pulse on a successful power-up |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_addr | input | 4 | Status group written |
| wr_data | input | DW | Bits to clear |
| rd_addr | input | 4 | Status group read |
| rd_data | output | DW | Status group contents |
| req_off | output | 1 | Immediate shutdown to off |
| req_imm | output | 1 | Immediate shutdown to init |
| req_seq | output | 1 | Sequenced shutdown to init |
| restart_ok | output | 1 | Automatic restart permitted |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The main function is exercised with single faults of each class, then with supply, over-temperature and short faults overlapping and released one by one. The single faults separate the three reactions. The overlap checks that priority picks exactly one request as the stronger faults go away. Masked faults are applied under all four mask-response codes, which tells apart "bit only", "bit and interrupt" and "nothing". Clear writes are made with the fault still present and after it has gone, and init-state entry follows both masked and shutdown faults, so that the two clearing rules are seen apart. Runs of back-to-back shutdown faults, with and without the retry limit, show the difference between the lock after the budget is spent and endless restart.

// File: rtl/pmic_flt_pkg.sv
package pmic_flt_pkg;
    typedef enum logic [1:0] {
        RS_RUN  = 2'd0,
        RS_WAIT = 2'd1,
        RS_LOCK = 2'd2
    } retry_st_e;

    localparam int NCLS  = 9;
    localparam int G_UV  = 0;
    localparam int G_OC  = 1;
    localparam int G_SCG = 2;
    localparam int G_THW = 3;
    localparam int G_OTS = 4;
    localparam int G_RV  = 5;
    localparam int G_RVT = 6;
    localparam int G_DTO = 7;
    localparam int G_SUP = 8;

    function automatic int grp_width(input int nreg);
        return (nreg > 3) ? nreg : 3;
    endfunction
endpackage

// File: rtl/pmic_flt_bank.sv
module pmic_flt_bank #(
    parameter int W        = 4,
    parameter bit MASKABLE = 1'b0,
    parameter bit SD_TYPE  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fault,
    input  logic [W-1:0] mask,
    input  logic [1:0]   mask_rsp,
    input  logic         rv_irq_quiet,
    input  logic [W-1:0] clr,
    input  logic         init_clr,
    output logic [W-1:0] st,
    output logic [W-1:0] sd_cond,
    output logic         irq_next
);
    logic [W-1:0] st_q, sd_q, rp_q;
    logic [W-1:0] mk, eff_sd, open_rpt, msk_f, set_v, rp_new, drop, keep;
    logic [W-1:0] st_n, sd_n, rp_n;

    always_comb begin
        mk       = MASKABLE ? mask : '0;
        eff_sd   = SD_TYPE ? (fault & ~mk) : '0;
        open_rpt = SD_TYPE ? '0 : (fault & ~mk);
        msk_f    = fault & mk;
        set_v    = eff_sd | open_rpt | (msk_f & {W{mask_rsp != 2'b00}});
        rp_new   = eff_sd
                 | (open_rpt & {W{!rv_irq_quiet}})
                 | (msk_f & {W{mask_rsp[1] && (SD_TYPE || !rv_irq_quiet)}});
        drop     = (clr & ~fault) | (init_clr ? ~sd_q : '0);
        keep     = st_q & ~drop;
        st_n     = set_v | keep;
        sd_n     = eff_sd | (sd_q & keep);
        rp_n     = rp_new | (rp_q & keep);
        irq_next = |(st_n & rp_n);
        sd_cond  = eff_sd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            sd_q <= '0;
            rp_q <= '0;
        end else begin
            st_q <= st_n;
            sd_q <= sd_n;
            rp_q <= rp_n;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/pmic_retry_fsm.sv
module pmic_retry_fsm
    import pmic_flt_pkg::*;
#(
    parameter int RETRY_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_any,
    input  logic unlimited,
    input  logic pu_done,
    input  logic en_in,
    output logic restart_ok
);
    localparam int CW = $clog2(RETRY_MAX + 2);
    localparam logic [CW-1:0] CMAX = CW'(RETRY_MAX);

    retry_st_e st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic sd_q, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_RUN;
            cnt_q <= '0;
            sd_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            sd_q  <= sd_any;
        end
    end

    always_comb begin
        hit   = sd_any && !sd_q;
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            RS_RUN: begin
                if (hit) begin
                    if (!unlimited && (CMAX == '0)) begin
                        st_n = RS_LOCK;
                    end else begin
                        st_n  = RS_WAIT;
                        cnt_n = CW'(1);
                    end
                end
            end
            RS_WAIT: begin
                if (hit) begin
                    if (!unlimited && (cnt_q >= CMAX)) begin
                        st_n = RS_LOCK;
                    end else if (cnt_q < CMAX) begin
                        cnt_n = cnt_q + CW'(1);
                    end
                end else if (pu_done) begin
                    st_n  = RS_RUN;
                    cnt_n = '0;
                end
            end
            RS_LOCK: begin
                st_n = RS_LOCK;
            end
            default: begin
                st_n  = RS_RUN;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_ok <= 1'b0;
        end else begin
            restart_ok <= (st_n == RS_WAIT) && !sd_any && en_in;
        end
    end
endmodule

// File: rtl/pmic_fault_mgr.sv
module pmic_fault_mgr
    import pmic_flt_pkg::*;
#(
    parameter int NREG      = 4,
    parameter int RETRY_MAX = 2,
    parameter int DW        = grp_width(NREG),
    parameter int AW        = $clog2(NCLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] flt_uv,
    input  logic [NREG-1:0] flt_oc_pos,
    input  logic [NREG-1:0] flt_oc_neg,
    input  logic [NREG-1:0] flt_scg,
    input  logic [NREG-1:0] flt_thw,
    input  logic [NREG-1:0] flt_ots,
    input  logic [NREG-1:0] flt_rv,
    input  logic [NREG-1:0] flt_rvtrip,
    input  logic [NREG-1:0] flt_dto,
    input  logic            sup_uv,
    input  logic            sup_ov,
    input  logic            sup_int,
    input  logic [NREG-1:0] mask_uv,
    input  logic [NREG-1:0] mask_thw,
    input  logic [NREG-1:0] mask_rv,
    input  logic [1:0]      mask_rsp,
    input  logic            rv_irq_quiet,
    input  logic            retry_unlimited,
    input  logic            en_in,
    input  logic            st_init,
    input  logic            pu_done,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            req_off,
    output logic            req_imm,
    output logic            req_seq,
    output logic            restart_ok,
    output logic            irq_n
);
    logic [DW-1:0] flt_a  [NCLS];
    logic [DW-1:0] mask_a [NCLS];
    logic [DW-1:0] st_a   [NCLS];
    logic [DW-1:0] sdc_a  [NCLS];
    logic [NCLS-1:0] irq_v;
    logic init_q, init_clr;
    logic off_c, ots_c, seq_c, sd_any;

    always_comb begin
        flt_a[G_UV]  = DW'(flt_uv);
        flt_a[G_OC]  = DW'(flt_oc_pos | flt_oc_neg);
        flt_a[G_SCG] = DW'(flt_scg);
        flt_a[G_THW] = DW'(flt_thw);
        flt_a[G_OTS] = DW'(flt_ots);
        flt_a[G_RV]  = DW'(flt_rv);
        flt_a[G_RVT] = DW'(flt_rvtrip);
        flt_a[G_DTO] = DW'(flt_dto);
        flt_a[G_SUP] = DW'({sup_int, sup_ov, sup_uv});
        for (int c = 0; c < NCLS; c++) mask_a[c] = '0;
        mask_a[G_UV]  = DW'(mask_uv);
        mask_a[G_THW] = DW'(mask_thw);
        mask_a[G_RV]  = DW'(mask_rv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= st_init;
    end
    assign init_clr = st_init && !init_q;

    for (genvar c = 0; c < NCLS; c++) begin : g_bank
        localparam bit MSK = (c == G_UV) || (c == G_THW) || (c == G_RV);
        localparam bit SDT = (c != G_RV);
        logic [DW-1:0] clr;
        assign clr = (wr_en && (wr_addr == AW'(c))) ? wr_data : '0;
        pmic_flt_bank #(.W(DW), .MASKABLE(MSK), .SD_TYPE(SDT)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .fault       (flt_a[c]),
            .mask        (mask_a[c]),
            .mask_rsp    (mask_rsp),
            .rv_irq_quiet(rv_irq_quiet),
            .clr         (clr),
            .init_clr    (init_clr),
            .st          (st_a[c]),
            .sd_cond     (sdc_a[c]),
            .irq_next    (irq_v[c])
        );
    end

    always_comb begin
        off_c  = |sdc_a[G_SUP];
        ots_c  = |sdc_a[G_OTS];
        seq_c  = |(sdc_a[G_UV] | sdc_a[G_OC] | sdc_a[G_SCG] | sdc_a[G_THW]
                 | sdc_a[G_RVT] | sdc_a[G_DTO]);
        sd_any = off_c || ots_c || seq_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_off <= 1'b0;
            req_imm <= 1'b0;
            req_seq <= 1'b0;
            irq_n   <= 1'b1;
        end else begin
            req_off <= off_c;
            req_imm <= ots_c && !off_c;
            req_seq <= seq_c && !ots_c && !off_c;
            irq_n   <= ~|irq_v;
        end
    end

    pmic_retry_fsm #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_any    (sd_any),
        .unlimited (retry_unlimited),
        .pu_done   (pu_done),
        .en_in     (en_in),
        .restart_ok(restart_ok)
    );

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (rd_addr == AW'(c)) rd_data = st_a[c];
        end
    end
endmodule

// File: rtl/pmic_fault_mgr_chk.sv
module pmic_fault_mgr_chk #(
    parameter int NREG = 4,
    parameter int DW   = 4,
    parameter int AW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sup_uv,
    input logic            sup_ov,
    input logic            sup_int,
    input logic [NREG-1:0] flt_ots,
    input logic [NREG-1:0] flt_scg,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   scg_stat,
    input logic            sd_any,
    input logic            req_off,
    input logic            req_imm,
    input logic            req_seq
);
    assert_req_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_off, req_imm, req_seq}));

    assert_supply_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_uv || sup_ov || sup_int) |=> req_off);

    assert_ots_imm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flt_ots) && !(sup_uv || sup_ov || sup_int)) |=> req_imm);

    assert_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_any |=> !(req_off || req_imm || req_seq));

    assert_w1c_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_scg[0] && wr_en && (wr_addr == AW'(2)) && wr_data[0]) |=> scg_stat[0]);
endmodule

bind pmic_fault_mgr pmic_fault_mgr_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sup_uv  (sup_uv),
    .sup_ov  (sup_ov),
    .sup_int (sup_int),
    .flt_ots (flt_ots),
    .flt_scg (flt_scg),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .scg_stat(st_a[2]),
    .sd_any  (sd_any),
    .req_off (req_off),
    .req_imm (req_imm),
    .req_seq (req_seq)
);

// File: tb/pmic_fault_mgr_bench.sv
`timescale 1ns/100ps
module pmic_fault_mgr_bench;
    localparam int NREG = 4;
    localparam int DW   = 4;
    localparam int AW   = 4;
    localparam int K_REQ = 0, K_IRQ = 1, K_RST = 2, K_RD = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NREG-1:0] flt_uv = '0, flt_oc_pos = '0, flt_oc_neg = '0, flt_scg = '0;
    logic [NREG-1:0] flt_thw = '0, flt_ots = '0, flt_rv = '0, flt_rvtrip = '0, flt_dto = '0;
    logic sup_uv = 1'b0, sup_ov = 1'b0, sup_int = 1'b0;
    logic [NREG-1:0] mask_uv = '0, mask_thw = '0, mask_rv = '0;
    logic [1:0] mask_rsp = 2'b00;
    logic rv_irq_quiet = 1'b0, retry_unlimited = 1'b0, en_in = 1'b1;
    logic st_init = 1'b0, pu_done = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic req_off, req_imm, req_seq, restart_ok, irq_n;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    kind;
        int    addr;
        int    val;
        string tag;
    } item_t;
    item_t q[$];

    pmic_fault_mgr #(.NREG(NREG), .RETRY_MAX(2)) u_pmic_fault_mgr (
        .clk(clk), .rst_n(rst_n),
        .flt_uv(flt_uv), .flt_oc_pos(flt_oc_pos), .flt_oc_neg(flt_oc_neg),
        .flt_scg(flt_scg), .flt_thw(flt_thw), .flt_ots(flt_ots), .flt_rv(flt_rv),
        .flt_rvtrip(flt_rvtrip), .flt_dto(flt_dto),
        .sup_uv(sup_uv), .sup_ov(sup_ov), .sup_int(sup_int),
        .mask_uv(mask_uv), .mask_thw(mask_thw), .mask_rv(mask_rv),
        .mask_rsp(mask_rsp), .rv_irq_quiet(rv_irq_quiet),
        .retry_unlimited(retry_unlimited), .en_in(en_in), .st_init(st_init),
        .pu_done(pu_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .req_off(req_off), .req_imm(req_imm), .req_seq(req_seq),
        .restart_ok(restart_ok), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // monitor: pops every item that falls due and compares it with the outputs
    always @(negedge clk) begin
        item_t it;
        int act;
        while (q.size() != 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            case (it.kind)
                K_REQ:   act = int'({req_off, req_imm, req_seq});
                K_IRQ:   act = int'(irq_n);
                K_RST:   act = int'(restart_ok);
                default: begin
                    rd_addr = AW'(it.addr);
                    #0.2;
                    act = int'(rd_data);
                end
            endcase
            checks++;
            if (act != it.val) begin
                errors++;
                $display("FAIL %s kind=%0d addr=%0d actual=%0h expected=%0h",
                         it.tag, it.kind, it.addr, act, it.val);
            end
        end
    end

    // driver side: expectations fall due one clock after the current inputs
    task automatic ex(input int kind, input int addr, input int val, input string tag);
        q.push_back('{cyc + 1, kind, addr, val, tag});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic w1c(input int addr, input int data);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
    endtask

    task automatic w1c_off();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R13: reset state
        ex(K_REQ, 0, 0, "R13 reset requests");
        ex(K_IRQ, 0, 1, "R13 reset irq_n");
        ex(K_RST, 0, 0, "R13 reset restart_ok");
        ex(K_RD, 1, 0, "R13 reset status");
        tick();

        // R1 negative overcurrent, R10 restart gating
        flt_oc_neg[2] = 1'b1;
        ex(K_REQ, 0, 1, "R1 overcurrent seq request");
        ex(K_IRQ, 0, 0, "R1 overcurrent irq");
        ex(K_RD, 1, 4'h4, "R1 overcurrent bit");
        ex(K_RST, 0, 0, "R10 no restart while fault");
        tick();
        flt_oc_neg[2] = 1'b0;
        ex(K_REQ, 0, 0, "R1 request drops");
        ex(K_RST, 0, 1, "R10 restart after fault gone");
        tick();
        en_in = 1'b0;
        ex(K_RST, 0, 0, "R10 restart needs enable");
        tick();
        en_in = 1'b1;
        ex(K_RST, 0, 1, "R10 restart with enable back");
        tick();
        pu_done = 1'b1;
        ex(K_RST, 0, 0, "R10 restart drops on power-up");
        tick();
        pu_done = 1'b0;
        w1c(1, 4'h4);
        ex(K_RD, 1, 0, "R7 clear when fault gone");
        ex(K_IRQ, 0, 1, "R7 irq released");
        tick();
        w1c_off();

        // R5 shared overcurrent bit, R7 clear blocked by present fault
        flt_oc_pos[1] = 1'b1;
        ex(K_RD, 1, 4'h2, "R5 positive limit bit");
        ex(K_REQ, 0, 1, "R1 positive limit request");
        tick();
        w1c(1, 4'h2);
        ex(K_RD, 1, 4'h2, "R7 clear blocked by fault");
        tick();
        w1c_off();
        flt_oc_pos[1] = 1'b0; flt_oc_neg[1] = 1'b1;
        ex(K_RD, 1, 4'h2, "R5 negative limit same bit");
        ex(K_REQ, 0, 1, "R5 negative limit request");
        tick();
        flt_oc_neg[1] = 1'b0;
        ex(K_REQ, 0, 0, "R1 request drops");
        tick();
        w1c(1, 4'h2); pu_done = 1'b1;
        ex(K_RD, 1, 0, "R7 clear after fault");
        ex(K_IRQ, 0, 1, "R7 irq released");
        tick();
        w1c_off(); pu_done = 1'b0;

        // R3 masked undervoltage, code 00
        mask_uv[0] = 1'b1; flt_uv[0] = 1'b1; mask_rsp = 2'b00;
        ex(K_REQ, 0, 0, "R3 masked no request");
        ex(K_RD, 0, 0, "R3 code 00 no bit");
        ex(K_IRQ, 0, 1, "R3 code 00 no irq");
        tick();
        // R4 code 01
        mask_rsp = 2'b01;
        ex(K_RD, 0, 4'h1, "R4 code 01 bit set");
        ex(K_IRQ, 0, 1, "R4 code 01 no irq");
        ex(K_REQ, 0, 0, "R3 masked no request");
        tick();
        // R4 code 10 on thermal warning
        mask_rsp = 2'b10; mask_thw[3] = 1'b1; flt_thw[3] = 1'b1;
        ex(K_RD, 3, 4'h8, "R4 code 10 bit set");
        ex(K_IRQ, 0, 0, "R4 code 10 irq");
        ex(K_REQ, 0, 0, "R3 masked warm no request");
        tick();
        mask_rsp = 2'b11; mask_uv[1] = 1'b1; flt_uv[1] = 1'b1;
        ex(K_RD, 0, 4'h3, "R4 code 11 bit set");
        ex(K_IRQ, 0, 0, "R4 code 11 irq");
        tick();
        flt_uv = '0; flt_thw = '0;
        ex(K_RD, 0, 4'h3, "R8 bits sticky before init");
        ex(K_RST, 0, 0, "R3 masked fault no retry");
        tick();
        st_init = 1'b1;
        ex(K_RD, 0, 0, "R8 init clears masked uv");
        ex(K_RD, 3, 0, "R8 init clears masked warm");
        ex(K_IRQ, 0, 1, "R8 irq released");
        tick();
        mask_uv = '0; mask_thw = '0; mask_rsp = 2'b00;

        // R2 unmasked warm, R8 shutdown bit kept
        st_init = 1'b0; flt_thw[0] = 1'b1;
        ex(K_REQ, 0, 1, "R2 warm seq request");
        ex(K_RD, 3, 4'h1, "R2 warm bit");
        ex(K_IRQ, 0, 0, "R2 warm irq");
        tick();
        flt_thw[0] = 1'b0; st_init = 1'b1;
        ex(K_RD, 3, 4'h1, "R8 shutdown bit kept");
        ex(K_RST, 0, 1, "R10 restart after warm");
        tick();
        st_init = 1'b0; pu_done = 1'b1; w1c(3, 4'h1);
        ex(K_RD, 3, 0, "R7 warm cleared");
        ex(K_IRQ, 0, 1, "R7 irq released");
        tick();
        pu_done = 1'b0; w1c_off();

        // R6 priority with overlapping faults
        sup_ov = 1'b1; flt_ots[1] = 1'b1; flt_scg[0] = 1'b1;
        ex(K_REQ, 0, 4, "R6 supply wins");
        ex(K_RD, 8, 4'h2, "R6 supply ov bit");
        ex(K_RD, 4, 4'h2, "R1 ots bit");
        ex(K_RD, 2, 4'h1, "R1 short bit");
        tick();
        sup_ov = 1'b0;
        ex(K_REQ, 0, 2, "R1 ots immediate");
        tick();
        flt_ots = '0;
        ex(K_REQ, 0, 1, "R1 short sequenced");
        tick();
        flt_scg = '0;
        ex(K_REQ, 0, 0, "R6 all released");
        ex(K_RST, 0, 1, "R10 restart after overlap");
        tick();
        sup_int = 1'b1;
        ex(K_REQ, 0, 4, "R6 internal rail off");
        ex(K_RD, 8, 4'h6, "R6 internal rail bit");
        tick();
        sup_int = 1'b0;
        ex(K_RST, 0, 1, "R10 restart after second fault");
        tick();
        pu_done = 1'b1; w1c(8, 4'h6);
        ex(K_RD, 8, 0, "R7 supply cleared");
        tick();
        pu_done = 1'b0; w1c(4, 4'h2);
        tick();
        w1c(2, 4'h1);
        ex(K_RD, 2, 0, "R7 short cleared");
        ex(K_IRQ, 0, 1, "R7 irq released");
        tick();
        w1c_off();

        // R9 residual voltage
        flt_rv[2] = 1'b1;
        ex(K_REQ, 0, 0, "R9 rv no request");
        ex(K_RD, 5, 4'h4, "R9 rv bit");
        ex(K_IRQ, 0, 0, "R9 rv irq");
        tick();
        flt_rv = '0; w1c(5, 4'h4);
        ex(K_RD, 5, 0, "R9 rv cleared");
        ex(K_IRQ, 0, 1, "R9 irq released");
        tick();
        w1c_off(); rv_irq_quiet = 1'b1; flt_rv[2] = 1'b1;
        ex(K_RD, 5, 4'h4, "R9 quiet rv bit");
        ex(K_IRQ, 0, 1, "R9 quiet rv no irq");
        ex(K_REQ, 0, 0, "R9 rv no request");
        tick();
        flt_rv = '0; flt_rvtrip[1] = 1'b1;
        ex(K_REQ, 0, 1, "R1 rv trip seq");
        ex(K_RD, 6, 4'h2, "R1 rv trip bit");
        ex(K_IRQ, 0, 0, "R9 trip irq despite quiet");
        tick();
        flt_rvtrip = '0; flt_dto[3] = 1'b1;
        ex(K_REQ, 0, 1, "R1 timeout seq");
        ex(K_RD, 7, 4'h8, "R1 timeout bit");
        tick();
        flt_dto = '0;
        ex(K_RST, 0, 1, "R10 restart after timeout");
        tick();
        pu_done = 1'b1; w1c(5, 4'h4);
        tick();
        pu_done = 1'b0; w1c(6, 4'h2);
        tick();
        w1c(7, 4'h8);
        ex(K_IRQ, 0, 1, "R9 all cleared irq");
        tick();
        w1c_off(); rv_irq_quiet = 1'b0;

        // R11 retry limit
        for (int n = 0; n < 3; n++) begin
            flt_scg[3] = 1'b1;
            ex(K_REQ, 0, 1, "R11 short request");
            tick();
            flt_scg[3] = 1'b0;
            ex(K_RST, 0, (n < 2) ? 1 : 0, "R11 restart per attempt");
            tick();
        end
        pu_done = 1'b1;
        ex(K_RST, 0, 0, "R11 locked after power-up");
        tick();
        pu_done = 1'b0;
        ex(K_RST, 0, 0, "R11 still locked");
        tick();
        do_reset();
        ex(K_RST, 0, 0, "R11 reset unlocks");
        ex(K_RD, 2, 0, "R13 status cleared by reset");
        tick();

        // R12 unlimited retries
        retry_unlimited = 1'b1;
        for (int n = 0; n < 4; n++) begin
            flt_scg[0] = 1'b1;
            tick();
            flt_scg[0] = 1'b0;
            ex(K_RST, 0, 1, "R12 restart without limit");
            tick();
        end
        pu_done = 1'b1;
        tick();
        pu_done = 1'b0;
        repeat (3) tick();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule